// File: doc/BRIEF.md
# Fail-First Vector Compare Sequencer

This unit steps a signed compare-with-immediate across a vector of up to `vl_i` elements, one element per clock. For each element it reads a source value from a small register file, compares it with a sign-extended immediate, and writes a 4-bit condition field to a condition-field file. The source and destination indices each either advance by one per element or stay fixed, chosen by two flags.

Each condition field is tested as soon as it is produced. The test picks one bit of the field and an expected polarity. The first element whose field fails the test ends the loop at once, and the vector length is rewritten. In inclusive mode the failing element is counted. In exclusive mode it is dropped, so the length can fall to zero. If no element fails, the length reported is the one requested. A single-cycle done pulse marks the end of every operation.

Top module: `ddff_cmp_seq`

## Requirements
- R1: The condition field for element i is written to `dst_idx_i + i` (modulo the file depth) when `dst_vec_i` is 1, and always to `dst_idx_i` when it is 0. Elements are written in ascending order, one per cycle.
- R2: Element i reads source register `src_idx_i + i` (modulo the file depth) when `src_vec_i` is 1, and always reads `src_idx_i` when it is 0.
- R3: A condition field is {lt, gt, eq, so} at bits 3, 2, 1, 0. The lt, gt and eq bits come from a signed compare of the source value against the immediate sign-extended to the data width, and exactly one of them is set. The so bit is always 0.
- R4: A field passes the test when bit `test_sel_i` of it equals `test_pol_i`. The first failing element is still written. No later element is written, and done follows in the next cycle.
- R5: On a failure at element i, `vl_o` becomes i+1 when `incl_i` is 1 and i when `incl_i` is 0. This includes zero when element 0 fails in exclusive mode.
- R6: When no element fails, exactly `vl_i` fields are written and `vl_o` equals `vl_i`.
- R7: A start with `vl_i` = 0 writes no field and gives done with `vl_o` = 0.
- R8: A start pulse that arrives while `busy_o` is 1 is ignored and does not alter the running operation.
- R9: With start sampled at clock edge 0, element j is written in the cycle after edge j. `done_o` is high for exactly one cycle, in the cycle after the last write, or after edge 0 when `vl_i` is 0. No field is written while `done_o` is high.
- R10: After reset, `busy_o`, `done_o` and `cf_we_o` are 0 and `vl_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle |
| vl_i | input | VL_W | Requested vector length |
| imm_i | input | IMM_W | Signed immediate |
| src_idx_i | input | RF_AW | First source register index |
| src_vec_i | input | 1 | Source index advances per element |
| dst_idx_i | input | CF_AW | First condition-field index |
| dst_vec_i | input | 1 | Destination index advances per element |
| test_sel_i | input | 2 | Bit of the condition field under test |
| test_pol_i | input | 1 | Value that bit must hold to pass |
| incl_i | input | 1 | 1 keeps the failing element in the length |
| rd_idx_o | output | RF_AW | Register file read index |
| rd_data_i | input | DATA_W | Register file read data, same cycle |
| cf_we_o | output | 1 | Condition-field write enable |
| cf_idx_o | output | CF_AW | Condition-field write index |
| cf_data_o | output | 4 | Condition-field write data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| vl_o | output | VL_W | Resulting vector length, held until the next done |

## Verification
The start pulse is driven on a falling edge, and the bench then counts falling edges from the edge that takes it. Element j's write must appear at count j+1, and done at the count after the last write, or at count 1 for a zero length. Each write is checked against a model of the register file and the compare at exactly that count, and any write outside its slot is reported. The resulting length is read in the done cycle. Once done has been seen, a few more idle edges are watched to confirm that no write follows a truncation. The ignored-start case drives a second start with different operands during the run. The writes that follow must still match the first operation.

// File: rtl/ddff_pkg.sv
package ddff_pkg;
  // condition field layout, bit 3 down to bit 0
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cf_t;

  localparam int unsigned CF_W = $bits(cf_t);

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_st_e;
endpackage

// File: rtl/ddff_idx_step.sv
module ddff_idx_step #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] base_i,
  input  logic         vec_i,
  input  logic         adv_i,
  output logic [W-1:0] idx_o
);
  logic [W-1:0] idx_q;
  logic         vec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      vec_q <= 1'b0;
    end else if (load_i) begin
      idx_q <= base_i;
      vec_q <= vec_i;
    end else if (adv_i && vec_q) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/ddff_compare.sv
module ddff_compare
  import ddff_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IMM_W  = 8
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [IMM_W-1:0]  imm_i,
  output cf_t               cf_o
);
  localparam int unsigned EXT_W = DATA_W - IMM_W;

  logic signed [DATA_W-1:0] a_s;
  logic signed [DATA_W-1:0] b_s;

  assign a_s = src_i;
  assign b_s = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};

  always_comb begin
    cf_o.lt = (a_s < b_s);
    cf_o.gt = (a_s > b_s);
    cf_o.eq = (a_s == b_s);
    cf_o.so = 1'b0;
  end
endmodule

// File: rtl/ddff_test.sv
module ddff_test
  import ddff_pkg::*;
(
  input  cf_t        cf_i,
  input  logic [1:0] sel_i,
  input  logic       pol_i,
  output logic       fail_o
);
  logic [CF_W-1:0] cf_bits;

  assign cf_bits = cf_i;
  assign fail_o  = (cf_bits[sel_i] != pol_i);
endmodule

// File: rtl/ddff_ctrl.sv
module ddff_ctrl
  import ddff_pkg::*;
#(
  parameter int unsigned VL_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [VL_W-1:0] vl_i,
  input  logic            incl_i,
  input  logic            fail_i,
  output logic            busy_o,
  output logic            load_o,
  output logic            adv_o,
  output logic            done_o,
  output logic [VL_W-1:0] vl_o
);
  seq_st_e         st_q;
  logic [VL_W-1:0] elem_q;
  logic [VL_W-1:0] vl_q;
  logic            incl_q;
  logic            done_q;
  logic [VL_W-1:0] vl_res_q;
  logic            last;

  assign load_o = (st_q == ST_IDLE) && start_i;
  assign busy_o = (st_q == ST_RUN);
  assign adv_o  = busy_o && !fail_i;
  assign last   = (elem_q == vl_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      elem_q   <= '0;
      vl_q     <= '0;
      incl_q   <= 1'b0;
      done_q   <= 1'b0;
      vl_res_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (load_o) begin
            if (vl_i == '0) begin
              done_q   <= 1'b1;
              vl_res_q <= '0;
            end else begin
              st_q   <= ST_RUN;
              elem_q <= '0;
              vl_q   <= vl_i;
              incl_q <= incl_i;
            end
          end
        end
        ST_RUN: begin
          if (fail_i) begin
            // cut short: failing element counted only when inclusive
            st_q     <= ST_IDLE;
            done_q   <= 1'b1;
            vl_res_q <= incl_q ? elem_q + 1'b1 : elem_q;
          end else if (last) begin
            st_q     <= ST_IDLE;
            done_q   <= 1'b1;
            vl_res_q <= vl_q;
          end else begin
            elem_q <= elem_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign vl_o   = vl_res_q;
endmodule

// File: rtl/ddff_cmp_seq.sv
module ddff_cmp_seq
  import ddff_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IMM_W  = 8,
  parameter int unsigned VL_W   = 4,
  parameter int unsigned RF_AW  = 4,
  parameter int unsigned CF_AW  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [RF_AW-1:0]  src_idx_i,
  input  logic              src_vec_i,
  input  logic [CF_AW-1:0]  dst_idx_i,
  input  logic              dst_vec_i,
  input  logic [1:0]        test_sel_i,
  input  logic              test_pol_i,
  input  logic              incl_i,
  output logic [RF_AW-1:0]  rd_idx_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              cf_we_o,
  output logic [CF_AW-1:0]  cf_idx_o,
  output logic [CF_W-1:0]   cf_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [VL_W-1:0]   vl_o
);
  logic             load, adv, fail, busy;
  logic [IMM_W-1:0] imm_q;
  logic [1:0]       sel_q;
  logic             pol_q;
  cf_t              cf;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imm_q <= '0;
      sel_q <= '0;
      pol_q <= 1'b0;
    end else if (load) begin
      imm_q <= imm_i;
      sel_q <= test_sel_i;
      pol_q <= test_pol_i;
    end
  end

  ddff_ctrl #(.VL_W(VL_W)) i_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .vl_i   (vl_i),
    .incl_i (incl_i),
    .fail_i (fail),
    .busy_o (busy),
    .load_o (load),
    .adv_o  (adv),
    .done_o (done_o),
    .vl_o   (vl_o)
  );

  ddff_idx_step #(.W(RF_AW)) i_src_idx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .base_i(src_idx_i),
    .vec_i (src_vec_i),
    .adv_i (adv),
    .idx_o (rd_idx_o)
  );

  ddff_idx_step #(.W(CF_AW)) i_dst_idx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .base_i(dst_idx_i),
    .vec_i (dst_vec_i),
    .adv_i (adv),
    .idx_o (cf_idx_o)
  );

  ddff_compare #(.DATA_W(DATA_W), .IMM_W(IMM_W)) i_cmp (
    .src_i(rd_data_i),
    .imm_i(imm_q),
    .cf_o (cf)
  );

  ddff_test i_test (
    .cf_i  (cf),
    .sel_i (sel_q),
    .pol_i (pol_q),
    .fail_o(fail)
  );

  assign busy_o    = busy;
  assign cf_we_o   = busy;
  assign cf_data_o = cf;
endmodule

// File: rtl/ddff_sva.sv
module ddff_sva #(
  parameter int unsigned VL_W  = 4,
  parameter int unsigned CF_AW = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             dst_vec_i,
  input logic [1:0]       test_sel_i,
  input logic             test_pol_i,
  input logic             cf_we_o,
  input logic [CF_AW-1:0] cf_idx_o,
  input logic [3:0]       cf_data_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [VL_W-1:0]  vl_o
);
  logic            dvec_l, pol_l;
  logic [1:0]      sel_l;
  logic [VL_W:0]   wcnt;
  logic            fail_l;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvec_l <= 1'b0;
      sel_l  <= '0;
      pol_l  <= 1'b0;
      wcnt   <= '0;
    end else if (start_i && !busy_o) begin
      dvec_l <= dst_vec_i;
      sel_l  <= test_sel_i;
      pol_l  <= test_pol_i;
      wcnt   <= '0;
    end else if (cf_we_o) begin
      wcnt <= wcnt + 1'b1;
    end
  end

  assign fail_l = (cf_data_o[sel_l] != pol_l);

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cf_we_o); // R9
  AST_STOP_ON_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cf_we_o && fail_l) |=> (done_o && !busy_o)); // R4
  AST_VL_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((VL_W+1)'(vl_o) == wcnt) || ((VL_W+1)'(vl_o) + 1'b1 == wcnt)); // R5
  AST_DST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cf_we_o && $past(cf_we_o) && !dvec_l) |-> (cf_idx_o == $past(cf_idx_o))); // R1
  AST_DST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cf_we_o && $past(cf_we_o) && dvec_l) |-> (cf_idx_o == CF_AW'($past(cf_idx_o) + 1'b1))); // R1
  AST_SO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cf_we_o |-> !cf_data_o[0]); // R3
  AST_ONE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cf_we_o |-> ($countones(cf_data_o[3:1]) == 1)); // R3
  AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o)); // R8
endmodule

bind ddff_cmp_seq ddff_sva #(.VL_W(VL_W), .CF_AW(CF_AW)) i_ddff_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .dst_vec_i (dst_vec_i),
  .test_sel_i(test_sel_i),
  .test_pol_i(test_pol_i),
  .cf_we_o   (cf_we_o),
  .cf_idx_o  (cf_idx_o),
  .cf_data_o (cf_data_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .vl_o      (vl_o)
);

// File: tb/test_ddff_cmp_seq.sv
module test_ddff_cmp_seq;
  localparam int DATA_W = 16, IMM_W = 8, VL_W = 4, RF_AW = 4, CF_AW = 4;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [VL_W-1:0]   vl_i = '0;
  logic [IMM_W-1:0]  imm_i = '0;
  logic [RF_AW-1:0]  src_idx_i = '0;
  logic              src_vec_i = 1'b0;
  logic [CF_AW-1:0]  dst_idx_i = '0;
  logic              dst_vec_i = 1'b0;
  logic [1:0]        test_sel_i = '0;
  logic              test_pol_i = 1'b0;
  logic              incl_i = 1'b0;
  logic [RF_AW-1:0]  rd_idx_o;
  logic [DATA_W-1:0] rd_data_i;
  logic              cf_we_o;
  logic [CF_AW-1:0]  cf_idx_o;
  logic [3:0]        cf_data_o;
  logic              busy_o, done_o;
  logic [VL_W-1:0]   vl_o;

  logic [DATA_W-1:0] rf [16];
  int total = 0, bad = 0;

  always #4 clk_i = ~clk_i;
  assign rd_data_i = rf[rd_idx_o];

  ddff_cmp_seq #(.DATA_W(DATA_W), .IMM_W(IMM_W), .VL_W(VL_W), .RF_AW(RF_AW), .CF_AW(CF_AW))
  i_ddff_cmp_seq (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] model_cf(input logic [DATA_W-1:0] v, input logic [IMM_W-1:0] imm);
    logic signed [DATA_W-1:0] a, b;
    a = v;
    b = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
    return {a < b, a > b, a == b, 1'b0};
  endfunction

  // one operation: model, drive, observe per-cycle; optional intruding start at count 2
  task automatic run_op(input string req, input int vl, input logic [7:0] imm,
                        input int src, input bit sv, input int dst, input bit dv,
                        input int sel, input bit pol, input bit incl, input bit intrude);
    int exp_idx[16];
    logic [3:0] exp_cf[16];
    int nw = 0, exp_vl, c, seen = 0;
    bit got_done = 0;
    exp_vl = vl;
    for (int i = 0; i < vl; i++) begin
      logic [3:0] f;
      f = model_cf(rf[sv ? (src + i) % 16 : src], imm);
      exp_idx[nw] = dv ? (dst + i) % 16 : dst;
      exp_cf[nw]  = f;
      nw++;
      if (f[sel] != pol) begin
        exp_vl = incl ? i + 1 : i;
        break;
      end
    end
    @(negedge clk_i);
    vl_i = VL_W'(vl); imm_i = imm; src_idx_i = RF_AW'(src); src_vec_i = sv;
    dst_idx_i = CF_AW'(dst); dst_vec_i = dv; test_sel_i = 2'(sel);
    test_pol_i = pol; incl_i = incl; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    c = 1;
    while (c <= 40) begin
      if (intrude && c == 2) begin
        start_i = 1'b1; vl_i = 4'd2; dst_idx_i = 4'd12; dst_vec_i = 1'b0;
        test_sel_i = 2'd0; test_pol_i = 1'b1; incl_i = 1'b0;
      end else begin
        start_i = 1'b0;
      end
      if (cf_we_o) begin
        if (seen < nw) begin
          chk(c == seen + 1, {req, " R9 write slot"}, c, seen + 1);
          chk(int'(cf_idx_o) == exp_idx[seen], {req, " R1 dst index"}, cf_idx_o, exp_idx[seen]);
          chk(cf_data_o == exp_cf[seen], {req, " R2 R3 field"}, cf_data_o, exp_cf[seen]);
        end else begin
          chk(1'b0, {req, " R4 write after stop"}, seen + 1, nw);
        end
        seen++;
      end
      if (done_o) begin
        got_done = 1;
        chk(c == nw + 1, {req, " R9 done cycle"}, c, nw + 1);
        chk(int'(vl_o) == exp_vl, {req, " R5 R6 vl"}, vl_o, exp_vl);
        break;
      end
      @(negedge clk_i);
      c++;
    end
    start_i = 1'b0;
    if (!got_done) chk(1'b0, {req, " watchdog"}, c, nw + 1);
    chk(seen == nw, {req, " R4 write count"}, seen, nw);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      chk(!cf_we_o && !done_o, {req, " R9 quiet after done"}, cf_we_o, 0);
    end
  endtask

  task automatic t_reset;
    chk(!busy_o && !done_o && !cf_we_o, "R10 idle flags", {busy_o, done_o, cf_we_o}, 0);
    chk(vl_o == '0, "R10 vl", vl_o, 0);
  endtask

  initial begin
    #(8 * 200000);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = DATA_W'(i * 7 - 40);
    rf[3] = 16'd5;
    rf[7] = 16'd5;
    #3 ;
    t_reset();
    @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    // R6: eq must stay 0, no element equals 100
    run_op("pass_all", 5, 8'd100, 0, 1, 2, 1, 1, 1'b0, 1'b1, 1'b0);
    // R5 inclusive stop at element 3 (rf[3]==5)
    run_op("incl_mid", 8, 8'd5, 0, 1, 0, 1, 1, 1'b0, 1'b1, 1'b0);
    // R5 exclusive stop at element 3
    run_op("excl_mid", 8, 8'd5, 0, 1, 4, 1, 1, 1'b0, 1'b0, 1'b0);
    // R5 so bit always 0 so element 0 fails: exclusive gives 0
    run_op("excl_zero", 6, 8'd0, 2, 1, 1, 1, 0, 1'b1, 1'b0, 1'b0);
    run_op("incl_one", 6, 8'd0, 2, 1, 1, 1, 0, 1'b1, 1'b1, 1'b0);
    // R2 scalar source, vector destination
    run_op("scalar_src", 4, 8'd0, 9, 0, 3, 1, 3, 1'b0, 1'b1, 1'b0);
    // R1 scalar destination, vector source
    run_op("scalar_dst", 5, 8'd0, 0, 1, 6, 0, 1, 1'b0, 1'b1, 1'b0);
    // R7 zero length
    run_op("zero_vl", 0, 8'd0, 0, 1, 0, 1, 0, 1'b1, 1'b1, 1'b0);
    // R3 signed: imm -3, negative values; fail when not greater
    run_op("signed_gt", 10, 8'hFD, 0, 1, 0, 1, 2, 1'b1, 1'b1, 1'b0);
    // R2 source index wraps, max length
    run_op("wrap_max", 15, 8'h80, 10, 1, 14, 1, 3, 1'b0, 1'b0, 1'b0);
    // R8 second start during run is ignored
    run_op("busy_start", 6, 8'd100, 8, 1, 0, 1, 1, 1'b0, 1'b1, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule